// File: doc/BRIEF.md
# Min/Max Frame Timing Checker

This block watches one test signal against a timing frame. A rising edge on the start input opens the frame. The frame has two parts. In the first part, a quiet region, the test signal must stay low. In the second part, a live region, the test signal must go high at least once before a deadline. When the frame ends, either by success or by a violation, the block returns to idle and waits for the next rising edge of start. Every violation produces a one-cycle error pulse and a cause code that names the violation.

The quiet length and the deadline are elaboration parameters. A third parameter selects what happens when start rises again while a frame is open. The new edge can be ignored, it can restart the frame, or it can be reported as an error. The block is meant to sit next to a design, as a synthesizable monitor. It works in simulation, in emulation and as a formal target. It keeps no history beyond its own counter and the last start value.

Top module: `frame_timing_checker`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the frame, the counter and the stored start value. After that edge `win_active_o` is 0, `err_o` is 0 and `cause_o` is 0.
- R2: The frame opens only on a rising edge of `start_i`, meaning start is 1 now and was 0 at the previous edge, sampled while idle. `win_active_o` is 1 after that edge. A start level held high does not reopen a frame. The value of `test_i` at the opening edge is not checked.
- R3: Edge k counts from 1, starting at the first edge after the opening edge. If `test_i` is 1 at any edge k with 1 ≤ k ≤ MIN_CYC, then after that edge `err_o` is 1, `cause_o` is 1 (early), and the frame closes.
- R4: MAX_CYC must be above MIN_CYC. If MAX_CYC is nonzero and `test_i` is still 0 at edge k = MAX_CYC, then after that edge `err_o` is 1, `cause_o` is 2 (missed deadline), and the frame closes.
- R5: Restart mode (NS_MODE = 1). A rising start edge at an edge k > MIN_CYC, with `test_i` at 0, restarts the count: the next edge is k = 1 again. No error is raised, and the missed-deadline check is skipped at that edge. A rising start edge inside the quiet region has no effect.
- R6: Error mode (NS_MODE = 2). A rising start edge while a frame is open raises `err_o` with `cause_o` = 3, and the open frame keeps its count.
- R7: Ignore mode (NS_MODE = 0). A rising start edge while a frame is open has no effect: no error, and the deadline stays where it was.
- R8: If `test_i` is 1 at an edge k > MIN_CYC, the frame closes without error. `err_o` is a single-cycle pulse. `cause_o` is 0 whenever `err_o` is 0.
- R9: If MIN_CYC is 0, the early check is off. If MAX_CYC is 0, the deadline check is off, and the frame stays open until `test_i` is seen.
- R10: If an early or missed-deadline violation happens at the same edge as a rising start edge in error mode, only the frame violation is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Trigger; its rising edge opens a frame |
| test_i | input | 1 | Signal whose timing is checked |
| err_o | output | 1 | One-cycle violation pulse, registered |
| cause_o | output | 2 | 1 early, 2 missed deadline, 3 illegal new start, 0 none |
| win_active_o | output | 1 | High while a frame is open |

## Verification
Suppose the frame counter drifts by one. Then an early error appears at the first live edge, or a deadline error appears one edge off from a cycle-exact model. The pulse after the offending edge shows this directly. A stored start value that is wrong shows up in the same cycle as either a missing open on `win_active_o` or a reopen on a held-high level. The wrong restart or new-start handling shows as an error or close at the old deadline instead of the new one. The bench drives four parameter variants from the same stimulus and compares all outputs every cycle. A fault is therefore seen within one cycle of the first edge where the wrong internal state changes a decision.

// File: rtl/ftc_pkg.sv
package ftc_pkg;

  // Handling of a rising start edge while a frame is already open.
  typedef enum logic [1:0] {
    NS_IGNORE  = 2'd0,
    NS_RESTART = 2'd1,
    NS_ERROR   = 2'd2
  } ns_mode_e;

  // Violation codes carried on cause_o.
  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_EARLY    = 2'd1,
    CAUSE_LATE     = 2'd2,
    CAUSE_NEWSTART = 2'd3
  } cause_e;

  // Saturation value of the edge counter.
  // Without a deadline, counting past the quiet region adds no information.
  function automatic int count_limit(int mn, int mx);
    return (mx == 0) ? mn + 1 : mx;
  endfunction

  function automatic int count_width(int lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // Edge k lies in the quiet region (test must stay low).
  function automatic logic in_quiet(int k, int mn);
    return (k >= 1) && (k <= mn);
  endfunction

  // Edge k lies in the live region (test may or must appear).
  function automatic logic in_live(int k, int mn);
    return k > mn;
  endfunction

  // Edge k is the last edge at which test may still appear.
  function automatic logic at_deadline(int k, int mx);
    return (mx != 0) && (k == mx);
  endfunction

  // Frame violations outrank a new-start report.
  function automatic cause_e pick_cause(logic early, logic late, logic ns);
    if (early)     return CAUSE_EARLY;
    else if (late) return CAUSE_LATE;
    else if (ns)   return CAUSE_NEWSTART;
    else           return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/ftc_rise_detect.sv
module ftc_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/ftc_window_track.sv
module ftc_window_track #(
  parameter int LIM = 8,
  parameter int CW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          open_i,
  input  logic          restart_i,
  input  logic          close_i,
  output logic          active_o,
  output logic [CW-1:0] age_o
);

  logic          active_q;
  logic [CW-1:0] age_q;
  logic          at_lim;

  assign at_lim = (age_q == CW'(LIM));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      age_q    <= '0;
    end else if (open_i || restart_i) begin
      active_q <= 1'b1;
      age_q    <= CW'(1);
    end else if (close_i) begin
      active_q <= 1'b0;
      age_q    <= '0;
    end else if (active_q && !at_lim) begin
      age_q    <= age_q + CW'(1);
    end
  end

  assign active_o = active_q;
  assign age_o    = age_q;

endmodule

// File: rtl/ftc_judge.sv
module ftc_judge
  import ftc_pkg::*;
#(
  parameter int       MIN_CYC = 3,
  parameter int       MAX_CYC = 8,
  parameter ns_mode_e NS_MODE = NS_RESTART,
  parameter int       CW      = 4
) (
  input  logic          active_i,
  input  logic [CW-1:0] age_i,
  input  logic          test_i,
  input  logic          rise_i,
  output logic          open_o,
  output logic          restart_o,
  output logic          close_o,
  output logic          early_o,
  output logic          late_o,
  output logic          nserr_o
);

  int   k;
  logic quiet, live, dline, hit, rise_busy;

  always_comb begin
    k         = int'(age_i);
    quiet     = active_i && in_quiet(k, MIN_CYC);
    live      = active_i && in_live(k, MIN_CYC);
    dline     = live && at_deadline(k, MAX_CYC);
    rise_busy = active_i && rise_i;
    hit       = live && test_i;
    early_o   = quiet && test_i;
    restart_o = (NS_MODE == NS_RESTART) && rise_busy && live && !test_i;
    late_o    = dline && !test_i && !restart_o;
    nserr_o   = (NS_MODE == NS_ERROR) && rise_busy && !early_o && !late_o;
    close_o   = early_o || hit || late_o;
    open_o    = !active_i && rise_i;
  end

endmodule

// File: rtl/ftc_err_reg.sv
module ftc_err_reg
  import ftc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       early_i,
  input  logic       late_i,
  input  logic       nserr_i,
  output logic       err_o,
  output logic [1:0] cause_o
);

  cause_e cause_d;
  logic   err_d;

  assign cause_d = pick_cause(early_i, late_i, nserr_i);
  assign err_d   = early_i | late_i | nserr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_o   <= 1'b0;
      cause_o <= 2'd0;
    end else begin
      err_o   <= err_d;
      cause_o <= err_d ? cause_d : 2'd0;
    end
  end

endmodule

// File: rtl/frame_timing_checker.sv
module frame_timing_checker
  import ftc_pkg::*;
#(
  parameter int       MIN_CYC = 3,
  parameter int       MAX_CYC = 8,
  parameter ns_mode_e NS_MODE = NS_RESTART
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       test_i,
  output logic       err_o,
  output logic [1:0] cause_o,
  output logic       win_active_o
);

  localparam int LIM = count_limit(MIN_CYC, MAX_CYC);
  localparam int CW  = count_width(LIM);

  // Internal events, named for the bound checker.
  logic          rise_w;
  logic          open_w;
  logic          restart_w;
  logic          close_w;
  logic          early_w;
  logic          late_w;
  logic          nserr_w;
  logic          active_w;
  logic [CW-1:0] age_w;

  ftc_rise_detect u_rise (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (start_i),
    .rise_o (rise_w)
  );

  ftc_judge #(
    .MIN_CYC (MIN_CYC),
    .MAX_CYC (MAX_CYC),
    .NS_MODE (NS_MODE),
    .CW      (CW)
  ) u_judge (
    .active_i  (active_w),
    .age_i     (age_w),
    .test_i    (test_i),
    .rise_i    (rise_w),
    .open_o    (open_w),
    .restart_o (restart_w),
    .close_o   (close_w),
    .early_o   (early_w),
    .late_o    (late_w),
    .nserr_o   (nserr_w)
  );

  ftc_window_track #(
    .LIM (LIM),
    .CW  (CW)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .open_i    (open_w),
    .restart_i (restart_w),
    .close_i   (close_w),
    .active_o  (active_w),
    .age_o     (age_w)
  );

  ftc_err_reg u_err (
    .clk     (clk),
    .rst     (rst),
    .early_i (early_w),
    .late_i  (late_w),
    .nserr_i (nserr_w),
    .err_o   (err_o),
    .cause_o (cause_o)
  );

  assign win_active_o = active_w;

endmodule

// File: rtl/ftc_sva.sv
module ftc_sva (
  input logic       clk,
  input logic       rst,
  input logic       test_i,
  input logic       rise_w,
  input logic       early_w,
  input logic       late_w,
  input logic       nserr_w,
  input logic       restart_w,
  input logic       err_o,
  input logic [1:0] cause_o,
  input logic       win_active_o
);

  // R2
  open_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!win_active_o && rise_w) |=> win_active_o);

  // R3
  early_report_chk: assert property (@(posedge clk) disable iff (rst)
    early_w |=> (err_o && cause_o == 2'd1 && !win_active_o));

  // R4
  late_report_chk: assert property (@(posedge clk) disable iff (rst)
    late_w |=> (err_o && cause_o == 2'd2 && !win_active_o));

  // R5
  restart_keeps_open_chk: assert property (@(posedge clk) disable iff (rst)
    restart_w |=> (win_active_o && !err_o));

  // R6
  newstart_report_chk: assert property (@(posedge clk) disable iff (rst)
    (nserr_w && !test_i) |=> (err_o && cause_o == 2'd3 && win_active_o));

  // R8
  cause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !err_o |-> (cause_o == 2'd0));

  // R8
  cause_valid_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (cause_o != 2'd0));

  // R10
  one_violation_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({early_w, late_w}) <= 1);

endmodule

bind frame_timing_checker ftc_sva u_sva (
  .clk          (clk),
  .rst          (rst),
  .test_i       (test_i),
  .rise_w       (rise_w),
  .early_w      (early_w),
  .late_w       (late_w),
  .nserr_w      (nserr_w),
  .restart_w    (restart_w),
  .err_o        (err_o),
  .cause_o      (cause_o),
  .win_active_o (win_active_o)
);

// File: tb/frame_timing_checker_tb.sv
module frame_timing_checker_tb;
  import ftc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  // Variants: 0 restart 3/8, 1 ignore 3/8, 2 error 3/8, 3 ignore 0/0
  localparam int P_MIN  [NI] = '{3, 3, 3, 0};
  localparam int P_MAX  [NI] = '{8, 8, 8, 0};
  localparam int P_MODE [NI] = '{1, 0, 2, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic test_i = 1'b0;

  logic       o_err   [NI];
  logic [1:0] o_cause [NI];
  logic       o_act   [NI];

  int checks = 0;
  int errors = 0;

  int m_prev [NI];
  int m_act  [NI];
  int m_age  [NI];
  int x_err  [NI];
  int x_cause[NI];
  int x_act  [NI];

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_timing_checker #(.MIN_CYC(3), .MAX_CYC(8), .NS_MODE(NS_RESTART)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .test_i(test_i),
    .err_o(o_err[0]), .cause_o(o_cause[0]), .win_active_o(o_act[0]));
  frame_timing_checker #(.MIN_CYC(3), .MAX_CYC(8), .NS_MODE(NS_IGNORE)) u_dut_ign (
    .clk(clk), .rst(rst), .start_i(start_i), .test_i(test_i),
    .err_o(o_err[1]), .cause_o(o_cause[1]), .win_active_o(o_act[1]));
  frame_timing_checker #(.MIN_CYC(3), .MAX_CYC(8), .NS_MODE(NS_ERROR)) u_dut_err (
    .clk(clk), .rst(rst), .start_i(start_i), .test_i(test_i),
    .err_o(o_err[2]), .cause_o(o_cause[2]), .win_active_o(o_act[2]));
  frame_timing_checker #(.MIN_CYC(0), .MAX_CYC(0), .NS_MODE(NS_IGNORE)) u_dut_nb (
    .clk(clk), .rst(rst), .start_i(start_i), .test_i(test_i),
    .err_o(o_err[3]), .cause_o(o_cause[3]), .win_active_o(o_act[3]));

  // Reference: restates the requirements with an unbounded edge count.
  task automatic model_step(input int i, input logic s, input logic t, input logic r);
    int  k;
    logic rise, early, hit, rs, late, ns;
    x_err[i] = 0; x_cause[i] = 0;
    if (r) begin
      m_prev[i] = 0; m_act[i] = 0; m_age[i] = 0;
    end else begin
      rise = s && (m_prev[i] == 0);
      m_prev[i] = s ? 1 : 0;
      if (m_act[i] == 0) begin
        if (rise) begin m_act[i] = 1; m_age[i] = 1; end
      end else begin
        k     = m_age[i];
        early = (k <= P_MIN[i]) && t;
        hit   = (k > P_MIN[i]) && t;
        rs    = (P_MODE[i] == 1) && rise && (k > P_MIN[i]) && !t;
        late  = (P_MAX[i] != 0) && (k == P_MAX[i]) && !t && !rs;
        ns    = (P_MODE[i] == 2) && rise && !early && !late;
        if (early)     begin x_err[i] = 1; x_cause[i] = 1; end
        else if (late) begin x_err[i] = 1; x_cause[i] = 2; end
        else if (ns)   begin x_err[i] = 1; x_cause[i] = 3; end
        if (rs) m_age[i] = 1;
        else if (early || hit || late) begin m_act[i] = 0; m_age[i] = 0; end
        else m_age[i] = m_age[i] + 1;
      end
    end
    x_act[i] = m_act[i];
  endtask

  task automatic compare_all();
    for (int i = 0; i < NI; i++) begin
      checks++;
      if (int'(o_act[i]) != x_act[i]) begin
        errors++;
        $display("FAIL R2 inst%0d active act=%0d exp=%0d", i, o_act[i], x_act[i]);
      end else if (int'(o_err[i]) != x_err[i] || int'(o_cause[i]) != x_cause[i]) begin
        errors++;
        $display("FAIL %s inst%0d err/cause act=%0d/%0d exp=%0d/%0d",
                 (x_cause[i] == 1) ? "R3" : (x_cause[i] == 2) ? "R4" :
                 (x_cause[i] == 3) ? "R6" : "R8",
                 i, o_err[i], o_cause[i], x_err[i], x_cause[i]);
      end
    end
  endtask

  // Drive one cycle from a negative edge and compare after the next one.
  task automatic cyc(input logic s, input logic t);
    start_i = s;
    test_i  = t;
    for (int i = 0; i < NI; i++) model_step(i, s, t, rst);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic chk(input int i, input string tag, input int e, input int c, input int a);
    checks++;
    if (int'(o_err[i]) != e || int'(o_cause[i]) != c || int'(o_act[i]) != a) begin
      errors++;
      $display("FAIL %s inst%0d err/cause/act act=%0d/%0d/%0d exp=%0d/%0d/%0d",
               tag, i, o_err[i], o_cause[i], o_act[i], e, c, a);
    end
  endtask

  initial begin
    int seed;
    logic s, t;
    seed = $urandom(32'd7151);
    @(negedge clk);
    do_reset();
    // R1 reset state
    for (int i = 0; i < NI; i++) chk(i, "R1", 0, 0, 0);

    // Early occurrence; zero bounds see a plain hit
    cyc(1, 0);
    chk(0, "R2", 0, 0, 1);
    cyc(1, 0);
    cyc(0, 1);
    chk(0, "R3", 1, 1, 0);
    chk(3, "R9", 0, 0, 0);
    cyc(0, 0);
    chk(0, "R8", 0, 0, 0);

    // Success in live region, then start held high
    do_reset();
    cyc(1, 0);
    repeat (3) cyc(1, 0);
    cyc(1, 1);
    chk(0, "R8", 0, 0, 0);
    cyc(1, 0);
    chk(0, "R2", 0, 0, 0);

    // Missed deadline
    do_reset();
    cyc(1, 0);
    repeat (7) cyc(0, 0);
    chk(0, "R4", 0, 0, 1);
    cyc(0, 0);
    chk(0, "R4", 1, 2, 0);
    chk(3, "R9", 0, 0, 1);

    // New start in live region under all three modes
    do_reset();
    cyc(1, 0);
    repeat (4) cyc(0, 0);
    cyc(1, 0);
    chk(0, "R5", 0, 0, 1);
    chk(1, "R7", 0, 0, 1);
    chk(2, "R6", 1, 3, 1);
    cyc(0, 0);
    cyc(0, 0);
    cyc(0, 0);
    chk(1, "R7", 1, 2, 0);
    chk(2, "R6", 1, 2, 0);
    chk(0, "R5", 0, 0, 1);
    repeat (4) cyc(0, 0);
    chk(0, "R5", 0, 0, 1);
    cyc(0, 0);
    chk(0, "R5", 1, 2, 0);

    // New start inside quiet region does not restart
    do_reset();
    cyc(1, 0);
    cyc(0, 0);
    cyc(1, 0);
    cyc(0, 0);
    cyc(0, 1);
    chk(0, "R5", 0, 0, 0);

    // Early plus new start together in error mode
    do_reset();
    cyc(1, 0);
    cyc(0, 0);
    cyc(1, 1);
    chk(2, "R10", 1, 1, 0);

    // Random traffic against the reference
    s = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      rst = ($urandom % 250) == 0;
      if (($urandom % 5) == 0) s = ~s;
      t = ($urandom % 7) == 0;
      cyc(s, t);
    end
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule